// File: doc/BRIEF.md
# Translation Lookaside Buffer with Invalidation

This block keeps a small, fully associative set of recently completed linear-to-physical page translations. It sits in front of a page table walker: a lookup presented on one cycle is answered in that same cycle with a hit flag, the composed physical address and a protection verdict. A lookup that finds no entry raises a miss, which is the walker's cue to start. When the walker finishes, it hands the finished translation back through the fill port.

Each entry maps either a 4 KB page or a 4 MB page, and both sizes can sit in the buffer together. Each entry also carries its write-enable and user-access permission bits, so a hit can be checked without a walk. Software-driven maintenance takes two forms. A page invalidate removes whatever entry covers one linear page. A write to the page-directory base register empties the whole buffer.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss and no hit.
- R2: A 4 KB entry matches a lookup when linear bits 31:12 equal its stored page number. The physical address is then the stored 20-bit frame number followed by linear bits 11:0, produced in the same cycle as the lookup.
- R3: A 4 MB entry (fill_big=1) matches a lookup on linear bits 31:22 only. The physical address is then frame bits 19:10 followed by linear bits 21:0.
- R4: Entries of 4 KB and 4 MB size are held together, and each answers lookups by its own rule.
- R5: There are 8 entries, written in round-robin order starting from entry 0 after reset. The ninth accepted fill overwrites the entry written by the first accepted fill.
- R6: A page invalidate (inv_valid) removes every entry that covers the linear page inv_vpage, whatever that entry's size. Entries that do not cover it are kept.
- R7: A pulse on base_wr invalidates every entry from the next cycle on.
- R8: An invalidate takes priority over a fill in the same cycle. A fill whose own page covers the invalidated page is dropped and does not advance the round-robin order. A fill that does not cover it is still written. A fill in the same cycle as base_wr is always dropped.
- R9: A hit raises lk_fault when the access is a write and the entry's rw bit is 0, or when the access is a user access and the entry's us bit is 0. A faulting hit does not raise lk_miss.
- R10: lk_miss is high exactly when lk_valid is high and no entry matches. All three outputs lk_hit, lk_miss and lk_fault are low when lk_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Linear address to translate |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is a user-level access |
| lk_hit | output | 1 | A valid entry matched |
| lk_miss | output | 1 | No entry matched; the walker should start |
| lk_fault | output | 1 | The entry that hit forbids this access |
| lk_paddr | output | 32 | Physical address, meaningful when lk_hit is high |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vpage | input | 20 | Linear bits 31:12 of the filled page |
| fill_pfn | input | 20 | Physical frame number (bits 31:12) |
| fill_big | input | 1 | Filled page is 4 MB |
| fill_rw | input | 1 | Page is writable |
| fill_us | input | 1 | Page is user-accessible |
| inv_valid | input | 1 | Invalidate one linear page |
| inv_vpage | input | 20 | Linear bits 31:12 of the page to invalidate |
| base_wr | input | 1 | Directory base register written: flush all |

## Verification
The bench goes after the cases where the two page sizes interact. A 4 MB entry must be removed by an invalidate that names any 4 KB page inside it. A design that compared full 20-bit page numbers against a large entry would leave that entry behind and keep answering with a stale frame. It would also compose a wrong physical address for any offset above bit 11. The bench also checks fills that arrive together with an invalidate or a flush. A design that let the fill win would bring back a translation that software has just removed, and a design that advanced the round-robin pointer on a dropped fill would evict the wrong entry later on. The last target is the eviction order itself: the ninth fill must displace the first, and permission faults must never raise a walk request.

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  input  logic        lk_write,
  input  logic        lk_user,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic        lk_fault,
  output logic [31:0] lk_paddr,
  input  logic        fill_valid,
  input  logic [19:0] fill_vpage,
  input  logic [19:0] fill_pfn,
  input  logic        fill_big,
  input  logic        fill_rw,
  input  logic        fill_us,
  input  logic        inv_valid,
  input  logic [19:0] inv_vpage,
  input  logic        base_wr
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, big, rw, us, hit_vec, inv_vec;
  logic [19:0]        tag [ENTRIES];
  logic [19:0]        pfn [ENTRIES];
  logic [PW-1:0]      ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] & (big[g] ? (tag[g][19:10] == lk_vaddr[31:22])
                                         : (tag[g] == lk_vaddr[31:12]));
    assign inv_vec[g] = inv_valid & vld[g] & (big[g] ? (tag[g][19:10] == inv_vpage[19:10])
                                                     : (tag[g] == inv_vpage));
  end

  logic [19:0] sel_pfn;
  logic        sel_big, sel_rw, sel_us;
  always_comb begin
    sel_pfn = '0;
    sel_big = 1'b0;
    sel_rw  = 1'b0;
    sel_us  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_pfn = pfn[i];
        sel_big = big[i];
        sel_rw  = rw[i];
        sel_us  = us[i];
      end
    end
  end

  assign lk_hit   = lk_valid & (|hit_vec);
  assign lk_miss  = lk_valid & ~(|hit_vec);
  assign lk_fault = lk_hit & ((lk_write & ~sel_rw) | (lk_user & ~sel_us));
  assign lk_paddr = sel_big ? {sel_pfn[19:10], lk_vaddr[21:0]} : {sel_pfn, lk_vaddr[11:0]};

  wire fill_hits_inv = inv_valid & (fill_big ? (fill_vpage[19:10] == inv_vpage[19:10])
                                             : (fill_vpage == inv_vpage));
  wire fill_take     = fill_valid & ~base_wr & ~fill_hits_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (base_wr) begin
      vld <= '0;
    end else begin
      vld <= vld & ~inv_vec;
      if (fill_take) begin
        vld[ptr] <= 1'b1;
        ptr      <= (ptr == PW'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_take) begin
      tag[ptr] <= fill_vpage;
      pfn[ptr] <= fill_pfn;
      big[ptr] <= fill_big;
      rw[ptr]  <= fill_rw;
      us[ptr]  <= fill_us;
    end
  end

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !lk_hit);

  assert_flush_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> !lk_hit);

  assert_inv_removes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !(lk_hit && lk_vaddr[31:12] == $past(inv_vpage)));

  assert_fill_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !base_wr && !inv_valid) |=>
      (!(lk_valid && lk_vaddr[31:12] == $past(fill_vpage)) || lk_hit));

  assert_super_read_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_write && !lk_user) |-> !lk_fault);

  assert_miss_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss}) && (lk_valid || !(lk_hit || lk_miss || lk_fault)));
endmodule

// File: tb/test_tlb_cache.sv
module test_tlb_cache;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic        fill_valid = 0, fill_big = 0, fill_rw = 0, fill_us = 0;
  logic [19:0] fill_vpage = '0, fill_pfn = '0, inv_vpage = '0;
  logic        inv_valid = 0, base_wr = 0;

  tlb_cache i_tlb_cache (.*);

  int total = 0, bad = 0;
  bit m_v[8], m_big[8], m_rw[8], m_us[8];
  logic [19:0] m_tag[8], m_pfn[8];
  int m_ptr = 0;

  function automatic bit covers(int i, logic [19:0] vp);
    return m_v[i] && (m_big[i] ? m_tag[i][19:10] == vp[19:10] : m_tag[i] == vp);
  endfunction

  function automatic int find(logic [19:0] vp);
    for (int i = 0; i < 8; i++) if (covers(i, vp)) return i;
    return -1;
  endfunction

  function automatic bit overlaps(logic [19:0] vp, bit bg);
    for (int i = 0; i < 8; i++)
      if (m_v[i] && ((bg || m_big[i]) ? m_tag[i][19:10] == vp[19:10] : m_tag[i] == vp)) return 1;
    return 0;
  endfunction

  task automatic tick(string req);
    int k;
    bit eh, em, ef;
    logic [31:0] ep;
    #5;
    k = lk_valid ? find(lk_vaddr[31:12]) : -1;
    eh = k >= 0;
    em = lk_valid && k < 0;
    ef = eh && ((lk_write && !m_rw[k]) || (lk_user && !m_us[k]));
    ep = '0;
    if (eh) ep = m_big[k] ? {m_pfn[k][19:10], lk_vaddr[21:0]} : {m_pfn[k], lk_vaddr[11:0]};
    total++;
    if (lk_hit !== eh || lk_miss !== em || lk_fault !== ef || (eh && lk_paddr !== ep)) begin
      bad++;
      $display("FAIL %s va=%h hit/miss/fault/pa=%b%b%b %h expected %b%b%b %h",
               req, lk_vaddr, lk_hit, lk_miss, lk_fault, lk_paddr, eh, em, ef, ep);
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (base_wr) begin
      for (int i = 0; i < 8; i++) m_v[i] = 0;
    end else begin
      bit drop;
      drop = inv_valid && (fill_big ? fill_vpage[19:10] == inv_vpage[19:10] : fill_vpage == inv_vpage);
      if (inv_valid) for (int i = 0; i < 8; i++) if (covers(i, inv_vpage)) m_v[i] = 0;
      if (fill_valid && !drop) begin
        m_v[m_ptr] = 1; m_tag[m_ptr] = fill_vpage; m_pfn[m_ptr] = fill_pfn;
        m_big[m_ptr] = fill_big; m_rw[m_ptr] = fill_rw; m_us[m_ptr] = fill_us;
        m_ptr = (m_ptr + 1) % 8;
      end
    end
    @(negedge clk);
    fill_valid = 0; inv_valid = 0; base_wr = 0;
  endtask

  task automatic look(logic [31:0] va, bit wr, bit usr, string req);
    lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = usr;
    tick(req);
    lk_valid = 0;
  endtask

  task automatic fill(logic [19:0] vp, logic [19:0] pf, bit bg, bit w, bit u);
    fill_valid = 1; fill_vpage = vp; fill_pfn = pf; fill_big = bg; fill_rw = w; fill_us = u;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick("R1"); tick("R1");
    rst_n = 1;
    look(32'h1234_5678, 0, 0, "R1");
    look(32'hC000_0000, 0, 1, "R10");
    fill(20'h00401, 20'h000AB, 0, 1, 1); tick("R2");
    look(32'h0040_1ABC, 0, 1, "R2");
    look(32'h0040_2ABC, 0, 0, "R2");
    fill(20'hC0000, 20'h00400, 1, 1, 0); tick("R3");
    look(32'hC012_3456, 0, 0, "R3");
    look(32'hC03F_FFFF, 1, 0, "R3");
    look(32'h0040_1000, 1, 0, "R4");
    look(32'hC040_0000, 0, 0, "R4");
    fill(20'h08000, 20'h12345, 0, 0, 0); tick("R9");
    look(32'h0800_0010, 1, 0, "R9");
    look(32'h0800_0010, 0, 1, "R9");
    look(32'h0800_0010, 0, 0, "R9");
    look(32'hC000_0004, 0, 1, "R9");
    inv_valid = 1; inv_vpage = 20'hC03FF; tick("R6");
    look(32'hC000_0000, 0, 0, "R6");
    look(32'h0040_1004, 0, 0, "R6");
    fill(20'h09000, 20'h00777, 0, 1, 1); inv_valid = 1; inv_vpage = 20'h09000; tick("R8");
    look(32'h0900_0000, 0, 0, "R8");
    fill(20'h0A000, 20'h00888, 0, 1, 1); inv_valid = 1; inv_vpage = 20'h00401; tick("R8");
    look(32'h0A00_0100, 0, 0, "R8");
    look(32'h0040_1100, 0, 0, "R8");
    fill(20'h0B000, 20'h00999, 0, 1, 1); base_wr = 1; tick("R7");
    look(32'h0A00_0100, 0, 0, "R7");
    look(32'h0B00_0100, 0, 0, "R8");
    for (int i = 0; i < 9; i++) begin
      fill(20'h10000 + 20'(i), 20'h00100 + 20'(i), 0, 1, 1); tick("R5");
    end
    for (int i = 0; i < 9; i++) look(32'h1000_0000 + 32'(i) * 32'h1000, 0, 0, "R5");
    base_wr = 1; tick("R7");
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] vp;
      bit bg;
      vp = {8'h00, 2'($urandom), 8'h00, 2'($urandom)};
      bg = ($urandom % 4) == 0;
      if (($urandom % 3) == 0 && !overlaps(vp, bg))
        fill(vp, 20'($urandom), bg, 1'($urandom), 1'($urandom));
      if (($urandom % 8) == 0) begin
        inv_valid = 1; inv_vpage = {8'h00, 2'($urandom), 8'h00, 2'($urandom)};
      end
      if (($urandom % 97) == 0) base_wr = 1;
      lk_valid = 1'($urandom);
      lk_vaddr = {8'h00, 2'($urandom), 8'h00, 2'($urandom), 12'($urandom)};
      lk_write = 1'($urandom); lk_user = 1'($urandom);
      tick("R10");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule